// File: doc/BRIEF.md
# Channel-Group Offset Allocator

The allocator sits after the sorting stage of an input-queued switch whose outlets are bundled into channel groups. Each group is a block of consecutive logical channel numbers, and the lowest number in the block identifies the group. In every slot the allocator receives one request per lane, already ordered so that requests for the same group sit next to each other. Within a group, the sorting stage puts the oldest head-of-line cell first.

For each request the block finds where its group's run starts. It gives the request its rank inside the run as an offset, so the first request of a group gets 0, the next gets 1, and so on. The offsets come from a segmented running-sum scan built from log2(LANES) adder stages, and the sum restarts at every group boundary.

A request wins when its offset does not exceed the capacity limit configured for its group. Each winner is steered to a physical port read from a logical-to-physical table at logical channel `group + offset`. Losing ports keep their head-of-line cell and request again in the next slot. Both tables are written through a small configuration port and are expected to stay fixed while traffic flows.

Top module: `chgrp_alloc`

## Requirements
- R1: While `rst` is high, and on the first output cycle after reset, `o_grant`, `o_offset` and `o_phys` are all zero. Reset loads the map table with the identity (entry k = k) and every capacity limit with 0.
- R2: The first lane of a run of equal group ids has offset 0. Each later valid lane of the same run has an offset equal to the number of valid lanes before it in that run. Lane k occupies bits [k*GW +: GW] of `i_grp`, bits [k*OFW +: OFW] of `o_offset` and bits [k*PW +: PW] of `o_phys`, where OFW = log2(LANES)+1.
- R3: A run restarts at lane 0 and at every lane whose group id differs from the lane below it. An invalid lane inside a run takes no offset and does not break the run.
- R4: A valid lane is granted exactly when its offset is less than or equal to the capacity limit stored for its group id.
- R5: A granted lane drives `o_phys` with the map table entry at index (group + offset) modulo 2^GW.
- R6: An invalid lane has grant 0, offset 0 and physical port 0. A valid lane that loses has physical port 0 but still reports its offset.
- R7: When `cfg_we` is high at a clock edge, `cfg_sel` = 0 writes `cfg_data[PW-1:0]` into the map table at `cfg_addr`, and `cfg_sel` = 1 writes `cfg_data[OFW-1:0]` into the capacity limit of group `cfg_addr`. Allocations from the next edge onward use the new value.
- R8: In one slot, no two granted lanes share the same group and offset. Adjacent valid lanes of one group have offsets that differ by exactly one. The grants per group equal min(requests, limit + 1).
- R9: Outputs are registered. They show the allocation of the inputs present at the most recent rising edge and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write enable |
| cfg_sel | input | 1 | Table select: 0 = map table, 1 = capacity limit |
| cfg_addr | input | GW | Logical channel or group id to write |
| cfg_data | input | max(PW, OFW) | Write data |
| i_valid | input | LANES | Request present on each lane |
| i_grp | input | LANES*GW | Group id per lane, sorted |
| o_grant | output | LANES | Lane won a channel |
| o_offset | output | LANES*OFW | Rank of the lane within its group run |
| o_phys | output | LANES*PW | Physical port of the granted channel |

## Verification
The scan is driven with several kinds of sorted input:
- a single group filling every lane, which exposes an offset carried too far or a cut-off at the wrong limit;
- many short runs and all-distinct groups, which show whether a restart is missed at a group change;
- a run with invalid holes, which separates "holes take no offset" from "holes break the run".

A zero-limit group placed next to a wide one checks that limits are looked up per group and not per lane. Table rewrites between slots, together with a reversed map, tell apart a lookup at `group + offset` from one at the group id or the lane index.

// File: rtl/chgrp_pkg.sv
package chgrp_pkg;

  typedef enum logic {
    TBL_MAP = 1'b0,
    TBL_CAP = 1'b1
  } tbl_sel_e;

  // Capacity test: offset may use every slot up to and including the limit.
  function automatic logic within_cap(input int unsigned off, input int unsigned lim);
    return off <= lim;
  endfunction

endpackage

// File: rtl/chgrp_boundary.sv
module chgrp_boundary #(
  parameter int LANES = 8,
  parameter int GW    = 3
) (
  input  logic [LANES*GW-1:0] grp,
  output logic [LANES-1:0]    head
);
  assign head[0] = 1'b1;
  for (genvar l = 1; l < LANES; l++) begin : g_cmp
    assign head[l] = grp[l*GW +: GW] != grp[(l-1)*GW +: GW];
  end
endmodule

// File: rtl/chgrp_segscan.sv
module chgrp_segscan #(
  parameter int LANES = 8,
  localparam int OFW = $clog2(LANES) + 1,
  localparam int STG = $clog2(LANES)
) (
  input  logic [LANES-1:0]     valid,
  input  logic [LANES-1:0]     head,
  output logic [LANES*OFW-1:0] offset
);
  logic [OFW-1:0] sm  [0:STG][0:LANES-1];
  logic           flg [0:STG][0:LANES-1];

  for (genvar l = 0; l < LANES; l++) begin : g_init
    assign sm[0][l]  = OFW'(valid[l]);
    assign flg[0][l] = head[l];
  end

  for (genvar s = 0; s < STG; s++) begin : g_stage
    localparam int D = 1 << s;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      if (l >= D) begin : g_add
        assign sm[s+1][l]  = flg[s][l] ? sm[s][l] : sm[s][l] + sm[s][l-D];
        assign flg[s+1][l] = flg[s][l] | flg[s][l-D];
      end else begin : g_pass
        assign sm[s+1][l]  = sm[s][l];
        assign flg[s+1][l] = flg[s][l];
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_out
    assign offset[l*OFW +: OFW] = valid[l] ? sm[STG][l] - OFW'(1) : '0;
  end
endmodule

// File: rtl/chgrp_tables.sv
module chgrp_tables
  import chgrp_pkg::*;
#(
  parameter int LANES = 8,
  parameter int GW    = 3,
  parameter int PW    = 3,
  localparam int OFW = $clog2(LANES) + 1,
  localparam int CDW = (PW > OFW) ? PW : OFW,
  localparam int DEP = 1 << GW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  tbl_sel_e             sel,
  input  logic [GW-1:0]        addr,
  input  logic [CDW-1:0]       data,
  input  logic [LANES*GW-1:0]  cap_idx,
  input  logic [LANES*GW-1:0]  map_idx,
  output logic [LANES*OFW-1:0] cap_rd,
  output logic [LANES*PW-1:0]  map_rd
);
  logic [PW-1:0]  map_q [DEP];
  logic [OFW-1:0] cap_q [DEP];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEP; k++) begin
        map_q[k] <= PW'(k);
        cap_q[k] <= '0;
      end
    end else if (we) begin
      if (sel == TBL_MAP) map_q[addr] <= data[PW-1:0];
      else                cap_q[addr] <= data[OFW-1:0];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign cap_rd[l*OFW +: OFW] = cap_q[cap_idx[l*GW +: GW]];
    assign map_rd[l*PW +: PW]   = map_q[map_idx[l*GW +: GW]];
  end
endmodule

// File: rtl/chgrp_alloc.sv
module chgrp_alloc
  import chgrp_pkg::*;
#(
  parameter int LANES = 8,
  parameter int GW    = 3,
  parameter int PW    = 3,
  localparam int OFW = $clog2(LANES) + 1,
  localparam int CDW = (PW > OFW) ? PW : OFW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic                 cfg_sel,
  input  logic [GW-1:0]        cfg_addr,
  input  logic [CDW-1:0]       cfg_data,
  input  logic [LANES-1:0]     i_valid,
  input  logic [LANES*GW-1:0]  i_grp,
  output logic [LANES-1:0]     o_grant,
  output logic [LANES*OFW-1:0] o_offset,
  output logic [LANES*PW-1:0]  o_phys
);
  // Named internal events, visible to the bound checker.
  logic [LANES-1:0]     run_head;
  logic [LANES*OFW-1:0] run_off;
  logic [LANES*OFW-1:0] grp_cap;
  logic [LANES*GW-1:0]  chan_idx;
  logic [LANES*PW-1:0]  chan_phys;
  logic [LANES-1:0]     grant_c;
  logic [LANES*PW-1:0]  phys_c;

  chgrp_boundary #(.LANES(LANES), .GW(GW)) u_bnd (
    .grp(i_grp), .head(run_head)
  );

  chgrp_segscan #(.LANES(LANES)) u_scan (
    .valid(i_valid), .head(run_head), .offset(run_off)
  );

  chgrp_tables #(.LANES(LANES), .GW(GW), .PW(PW)) u_tbl (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(tbl_sel_e'(cfg_sel)),
    .addr(cfg_addr), .data(cfg_data),
    .cap_idx(i_grp), .map_idx(chan_idx),
    .cap_rd(grp_cap), .map_rd(chan_phys)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign chan_idx[l*GW +: GW] = i_grp[l*GW +: GW] + GW'(run_off[l*OFW +: OFW]);
    assign grant_c[l] = i_valid[l] &&
                        within_cap(int'(run_off[l*OFW +: OFW]), int'(grp_cap[l*OFW +: OFW]));
    assign phys_c[l*PW +: PW] = grant_c[l] ? chan_phys[l*PW +: PW] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_grant  <= '0;
      o_offset <= '0;
      o_phys   <= '0;
    end else begin
      o_grant  <= grant_c;
      o_offset <= run_off;
      o_phys   <= phys_c;
    end
  end
endmodule

// File: rtl/chgrp_alloc_chk.sv
module chgrp_alloc_chk #(
  parameter int LANES = 8,
  parameter int GW    = 3,
  localparam int OFW = $clog2(LANES) + 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [LANES-1:0]     i_valid,
  input logic [LANES*GW-1:0]  i_grp,
  input logic [LANES-1:0]     run_head,
  input logic [LANES-1:0]     o_grant,
  input logic [LANES*OFW-1:0] o_offset
);
  for (genvar l = 0; l < LANES; l++) begin : g_a
    assert_grant_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
      o_grant[l] |-> $past(i_valid[l]));

    assert_head_zero_R2: assert property (@(posedge clk) disable iff (rst)
      (run_head[l] && i_valid[l]) |=> o_offset[l*OFW +: OFW] == '0);

    assert_idle_lane_R6: assert property (@(posedge clk) disable iff (rst)
      !i_valid[l] |=> (o_offset[l*OFW +: OFW] == '0 && !o_grant[l]));

    if (l > 0) begin : g_pair
      assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
        (i_valid[l] && i_grp[l*GW +: GW] != i_grp[(l-1)*GW +: GW])
        |=> o_offset[l*OFW +: OFW] == '0);

      assert_consecutive_R8: assert property (@(posedge clk) disable iff (rst)
        (i_valid[l] && i_valid[l-1] && i_grp[l*GW +: GW] == i_grp[(l-1)*GW +: GW])
        |=> o_offset[l*OFW +: OFW] == o_offset[(l-1)*OFW +: OFW] + OFW'(1));
    end
  end
endmodule

bind chgrp_alloc chgrp_alloc_chk #(.LANES(LANES), .GW(GW)) u_chk (
  .clk(clk), .rst(rst), .i_valid(i_valid), .i_grp(i_grp),
  .run_head(run_head), .o_grant(o_grant), .o_offset(o_offset)
);

// File: tb/chgrp_alloc_test.sv
`timescale 1ns/1ps
module chgrp_alloc_test;
  localparam int LANES = 8;
  localparam int GW = 3;
  localparam int PW = 3;
  localparam int OFW = 4;
  localparam int CDW = 4;

  typedef struct packed {
    logic [7:0]  v;
    logic [23:0] g;
    logic [7:0]  m;
  } vec_t;

  // Group ids are written lane 7 first ... lane 0 last; m is the expected grant mask.
  localparam vec_t VECS [7] = '{
    '{8'hFF, {3'd5,3'd2,3'd2,3'd2,3'd2,3'd0,3'd0,3'd0}, 8'hBB},
    '{8'hFF, {3'd6,3'd6,3'd6,3'd6,3'd6,3'd6,3'd6,3'd6}, 8'h03},
    '{8'h0F, {3'd7,3'd7,3'd7,3'd7,3'd6,3'd5,3'd2,3'd0}, 8'h0F},
    '{8'hFF, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 8'hFF},
    '{8'h7B, {3'd2,3'd2,3'd2,3'd2,3'd2,3'd2,3'd2,3'd2}, 8'h0B},
    '{8'hFF, {3'd5,3'd5,3'd2,3'd2,3'd2,3'd2,3'd0,3'd0}, 8'h5F},
    '{8'h00, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 8'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic cfg_sel = 1'b0;
  logic [GW-1:0] cfg_addr = '0;
  logic [CDW-1:0] cfg_data = '0;
  logic [LANES-1:0] i_valid = '0;
  logic [LANES*GW-1:0] i_grp = '0;
  logic [LANES-1:0] o_grant;
  logic [LANES*OFW-1:0] o_offset;
  logic [LANES*PW-1:0] o_phys;

  int tests = 0;
  int fails = 0;
  int mdl_map [8];
  int mdl_cap [8];
  bit done = 1'b0;

  always #4 clk = ~clk;

  chgrp_alloc #(.LANES(LANES), .GW(GW), .PW(PW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .i_valid(i_valid), .i_grp(i_grp),
    .o_grant(o_grant), .o_offset(o_offset), .o_phys(o_phys)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_tbl(input bit sel, input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = GW'(addr); cfg_data = CDW'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) mdl_cap[addr] = data; else mdl_map[addr] = data;
  endtask

  // Drive a slot and compare against the reference model one edge later.
  task automatic run_slot(input logic [7:0] v, input logic [23:0] g, input int mask, input bit use_mask);
    int cnt, offs [8], phs [8];
    int reqs [8], wins [8];
    bit gr [8];
    @(negedge clk);
    i_valid = v; i_grp = g;
    cnt = 0;
    for (int k = 0; k < 8; k++) begin reqs[k] = 0; wins[k] = 0; end
    for (int l = 0; l < LANES; l++) begin
      int gid = int'(g[l*GW +: GW]);
      if (l == 0 || gid != int'(g[(l-1)*GW +: GW])) cnt = 0;
      offs[l] = 0; gr[l] = 1'b0; phs[l] = 0;
      if (v[l]) begin
        offs[l] = cnt; cnt++;
        reqs[gid]++;
        gr[l] = offs[l] <= mdl_cap[gid];
        if (gr[l]) begin
          phs[l] = mdl_map[(gid + offs[l]) % 8];
          wins[gid]++;
        end
      end
    end
    @(negedge clk);
    if (use_mask) check("R4 grant mask", int'(o_grant), mask);
    for (int l = 0; l < LANES; l++) begin
      check("R2/R3 offset", int'(o_offset[l*OFW +: OFW]), offs[l]);
      check("R4/R6 grant", int'(o_grant[l]), int'(gr[l]));
      check("R5/R6 phys", int'(o_phys[l*PW +: PW]), phs[l]);
    end
    for (int k = 0; k < 8; k++) begin
      int got = 0;
      for (int l = 0; l < LANES; l++)
        if (o_grant[l] && int'(g[l*GW +: GW]) == k) got++;
      check("R8 per-group grants", got, (reqs[k] < mdl_cap[k] + 1) ? reqs[k] : mdl_cap[k] + 1);
      if (got != wins[k]) check("R8 model consistency", got, wins[k]);
    end
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin mdl_map[k] = k; mdl_cap[k] = 0; end
    i_valid = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset, even with requests present.
    check("R1 grant in reset", int'(o_grant), 0);
    check("R1 offset in reset", int'(o_offset), 0);
    check("R1 phys in reset", int'(o_phys), 0);
    i_valid = '0;
    rst = 1'b0;
    @(negedge clk);
    check("R1 grant after reset", int'(o_grant), 0);

    // R1/R7: identity map and zero limits after reset.
    run_slot(8'h0F, {3'd7,3'd7,3'd7,3'd7,3'd3,3'd3,3'd1,3'd1}, 8'h05, 1'b1);

    // R7: load limits and a reversed map.
    write_tbl(1'b1, 0, 1);
    write_tbl(1'b1, 2, 2);
    write_tbl(1'b1, 5, 0);
    write_tbl(1'b1, 6, 1);
    for (int k = 0; k < 8; k++) write_tbl(1'b0, k, 7 - k);

    for (int n = 0; n < 7; n++) run_slot(VECS[n].v, VECS[n].g, int'(VECS[n].m), 1'b1);

    // R9: outputs stay put until the next edge after inputs change.
    run_slot(VECS[3].v, VECS[3].g, 8'hFF, 1'b1);
    @(negedge clk);
    i_valid = 8'h00;
    #2;
    check("R9 hold before edge", int'(o_grant), 8'hFF);
    @(negedge clk);
    check("R9 update after edge", int'(o_grant), 0);

    // R7: raise a limit, then rewrite one map entry.
    write_tbl(1'b1, 6, 7);
    run_slot(VECS[1].v, VECS[1].g, 8'hFF, 1'b1);
    write_tbl(1'b0, 0, 5);
    run_slot(8'h01, 24'd0, 8'h01, 1'b1);
    check("R7 rewritten map entry", int'(o_phys[2:0]), 5);

    // R1: reset in mid-run clears outputs.
    @(negedge clk);
    i_valid = 8'hFF; i_grp = '0; rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", int'(o_grant), 0);
    rst = 1'b0; i_valid = '0;
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule